// File: doc/BRIEF.md
# SPI Peripheral Framing Engine with Host Interrupt

This block is the peripheral side of a half-duplex SPI protocol for a co-processor. While the host holds chip select low, the block collects command bytes and passes them to internal logic. It keeps the MISO line at the all-ones filler byte until internal logic says a response is ready. It then shifts the response out one byte at a time. The internal logic presents each byte and flags the last one. After the last byte the filler returns.

An active-low interrupt line tells the host when to act. It falls when a response becomes ready inside an open frame. It also falls when chip select is idle and unsolicited output is waiting. It is edge-oriented: it rises again after the next complete byte arrives, and it then stays high for a programmable minimum number of system clocks before it may fall again.

Chip select going idle always returns the framing logic to its receive-ready state and drops any partial byte. If chip select is already low when reset ends, all SCK traffic is ignored until chip select first goes high. SCK, chip select and MOSI are brought into the system clock domain by synchronizers. Bits are sampled on the rising SCK edge, most significant bit first (SPI mode 0).

Top module: `spi_link_engine`

## Requirements
- R1: While a command is being received, and while the response is not yet ready, every byte the host clocks returns 0xFF on MISO. After the last response byte, every byte returns 0xFF until chip select goes idle.
- R2: When `rsp_ready_i` is high inside an active frame and the hold-off has expired, `hint_n_o` goes low within a few system clocks.
- R3: The response is loaded at the next byte boundary after `rsp_ready_i` is seen. Its bytes are shifted out MSB first, in the order presented, with one `rsp_take_o` pulse per byte. The byte presented with `rsp_last_i` high is the final one. A response is 2 to 136 bytes long, and its first byte is never 0xFF.
- R4: Once `hint_n_o` is low, it returns high after the next complete byte is received on SCK.
- R5: After `hint_n_o` rises, it stays high for at least `MIN_HIGH_CYC` system clocks (default 1250, which is 25 µs at 50 MHz).
- R6: With chip select idle and `rsp_pending_i` high, `hint_n_o` goes low once the hold-off has expired.
- R7: Chip select going idle returns the engine to its receive state from any phase and discards a partial byte. The next frame starts fresh, with 0xFF on MISO and byte alignment taken from its first SCK edge.
- R8: If chip select is low when reset ends, no byte is reported and MISO stays 1 until chip select first goes idle. The frame after that works normally.
- R9: `rsp_pending_i` does not pull `hint_n_o` low while chip select is active. The interrupt for pending output comes only after chip select is deasserted.
- R10: Every byte received in the receive phase appears on `rx_byte_o` with a single-cycle `rx_valid_o` pulse. Bytes clocked during the response or after it are not reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sck_i | input | 1 | SPI clock from host (mode 0) |
| cs_n_i | input | 1 | Chip select from host, active low |
| mosi_i | input | 1 | Serial data from host |
| miso_o | output | 1 | Serial data to host |
| hint_n_o | output | 1 | Host interrupt, active low |
| rx_byte_o | output | BYTE_BITS | Received command byte |
| rx_valid_o | output | 1 | One-cycle strobe for `rx_byte_o` |
| rsp_ready_i | input | 1 | Internal logic has a response for the current frame |
| rsp_pending_i | input | 1 | Internal logic has unsolicited output waiting |
| rsp_data_i | input | BYTE_BITS | Response byte presented by internal logic |
| rsp_last_i | input | 1 | Presented response byte is the final one |
| rsp_take_o | output | 1 | Presented response byte was loaded into the shifter |

## Verification
The hardest state to reach from the ports is a reset that ends while chip select is still low in the middle of a frame. The bench holds chip select low, pulses reset, and keeps clocking whole bytes. It expects silence on the receive strobe and ones on MISO. It then releases chip select and checks that the next frame is received. The interrupt hold-off is also hard to hit, because a pending request must arrive while the counter is still running. The bench releases the interrupt inside a frame, closes the frame at once with output pending, and measures how long the line stays high before it falls again.

// File: rtl/spi_link_pkg.sv
package spi_link_pkg;
  typedef enum logic [2:0] {
    S_GUARD,
    S_IDLE,
    S_RECV,
    S_RSP,
    S_DONE
  } frame_st_t;
endpackage

// File: rtl/spi_link_sync.sv
module spi_link_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3
) (
  input  logic             clk,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] pipe [STAGES];

  always_ff @(posedge clk) pipe[0] <= async_i;

  generate
    for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) pipe[g] <= pipe[g-1];
    end
  endgenerate

  assign sync_o = pipe[STAGES-1];
endmodule

// File: rtl/spi_link_shifter.sv
module spi_link_shifter #(
  parameter int BITS = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clr,
  input  logic            sck_rise,
  input  logic            mosi,
  input  logic            load,
  input  logic [BITS-1:0] load_val,
  output logic            byte_done,
  output logic [BITS-1:0] rx_byte,
  output logic            miso
);
  localparam int CW = (BITS > 1) ? $clog2(BITS) : 1;
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  logic [CW-1:0]   cnt_q;
  logic [BITS-1:0] rx_q;
  logic [BITS-1:0] tx_q;
  logic            done_q;
  logic            miso_q;

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q  <= '0;
      rx_q   <= '0;
      tx_q   <= '1;
      done_q <= 1'b0;
      miso_q <= 1'b1;
    end else begin
      done_q <= 1'b0;
      if (sck_rise) begin
        rx_q <= {rx_q[BITS-2:0], mosi};
        if (cnt_q == LAST_BIT) begin
          cnt_q  <= '0;
          done_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (load) tx_q <= load_val;
      miso_q <= tx_q[LAST_BIT - cnt_q];
    end
  end

  assign byte_done = done_q;
  assign rx_byte   = rx_q;
  assign miso      = miso_q;
endmodule

// File: rtl/spi_link_hint.sv
module spi_link_hint #(
  parameter int MIN_HIGH_CYC = 1250
) (
  input  logic clk,
  input  logic rst,
  input  logic want_low,
  input  logic release_i,
  output logic hint_n
);
  localparam int HW = $clog2(MIN_HIGH_CYC + 1);
  localparam logic [HW-1:0] HOLD_LOAD = HW'(MIN_HIGH_CYC);

  logic [HW-1:0] hold_q;
  logic          hint_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hint_q <= 1'b1;
      hold_q <= '0;
    end else if (!hint_q) begin
      if (release_i) begin
        hint_q <= 1'b1;
        hold_q <= HOLD_LOAD;
      end
    end else if (hold_q != '0) begin
      hold_q <= hold_q - 1'b1;
    end else if (want_low) begin
      hint_q <= 1'b0;
    end
  end

  assign hint_n = hint_q;

  // checker: independent count of high cycles, saturating
  logic [HW-1:0] high_cnt;
  always_ff @(posedge clk) begin
    if (rst) high_cnt <= HOLD_LOAD;
    else if (!hint_q) high_cnt <= '0;
    else if (high_cnt != HOLD_LOAD) high_cnt <= high_cnt + 1'b1;
  end

  a_r5_min_high: assert property (@(posedge clk) disable iff (rst)
    $fell(hint_n) |-> (high_cnt >= HOLD_LOAD));

  a_r4_release: assert property (@(posedge clk) disable iff (rst)
    (!hint_n && release_i) |=> hint_n);
endmodule

// File: rtl/spi_link_engine.sv
module spi_link_engine
  import spi_link_pkg::*;
#(
  parameter int SYNC_STAGES  = 2,
  parameter int BYTE_BITS    = 8,
  parameter int MIN_HIGH_CYC = 1250,
  parameter int RSP_MIN_LEN  = 2,
  parameter int RSP_MAX_LEN  = 136
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sck_i,
  input  logic                 cs_n_i,
  input  logic                 mosi_i,
  output logic                 miso_o,
  output logic                 hint_n_o,
  output logic [BYTE_BITS-1:0] rx_byte_o,
  output logic                 rx_valid_o,
  input  logic                 rsp_ready_i,
  input  logic                 rsp_pending_i,
  input  logic [BYTE_BITS-1:0] rsp_data_i,
  input  logic                 rsp_last_i,
  output logic                 rsp_take_o
);
  localparam logic [BYTE_BITS-1:0] FILL = '1;
  localparam int LW = $clog2(RSP_MAX_LEN + 2);

  logic [2:0] raw_in, syn_in;
  logic       cs_s, sck_s, mosi_s, sck_d_q, sck_rise;

  assign raw_in = {mosi_i, sck_i, cs_n_i};

  spi_link_sync #(.STAGES(SYNC_STAGES), .WIDTH(3)) u_sync (
    .clk(clk), .async_i(raw_in), .sync_o(syn_in)
  );

  assign cs_s   = syn_in[0];
  assign sck_s  = syn_in[1];
  assign mosi_s = syn_in[2];

  always_ff @(posedge clk) begin
    if (rst) sck_d_q <= 1'b0;
    else     sck_d_q <= sck_s;
  end
  assign sck_rise = sck_s && !sck_d_q;

  frame_st_t            st_q, st_d;
  logic                 last_q, last_d;
  logic                 load, take, byte_done, shf_clr;
  logic [BYTE_BITS-1:0] load_val, rx_byte;

  always_comb begin
    st_d     = st_q;
    last_d   = last_q;
    load     = 1'b0;
    take     = 1'b0;
    load_val = FILL;
    unique case (st_q)
      S_GUARD: if (cs_s) st_d = S_IDLE;
      S_IDLE:  if (!cs_s) st_d = S_RECV;
      S_RECV: if (byte_done) begin
        load = 1'b1;
        if (rsp_ready_i) begin
          load_val = rsp_data_i;
          take     = 1'b1;
          last_d   = rsp_last_i;
          st_d     = S_RSP;
        end
      end
      S_RSP: if (byte_done) begin
        load = 1'b1;
        if (last_q) begin
          st_d = S_DONE;
        end else begin
          load_val = rsp_data_i;
          take     = 1'b1;
          last_d   = rsp_last_i;
        end
      end
      S_DONE: if (byte_done) load = 1'b1;
      default: st_d = S_IDLE;
    endcase
    if (cs_s && st_q != S_GUARD) begin
      st_d = S_IDLE;
      take = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q       <= S_GUARD;
      last_q     <= 1'b0;
      rx_valid_o <= 1'b0;
      rx_byte_o  <= '0;
    end else begin
      st_q       <= st_d;
      last_q     <= last_d;
      rx_valid_o <= byte_done && (st_q == S_RECV) && !cs_s;
      if (byte_done) rx_byte_o <= rx_byte;
    end
  end

  assign rsp_take_o = take;
  assign shf_clr    = cs_s || (st_q == S_GUARD);

  spi_link_shifter #(.BITS(BYTE_BITS)) u_shf (
    .clk(clk), .rst(rst), .clr(shf_clr), .sck_rise(sck_rise), .mosi(mosi_s),
    .load(load), .load_val(load_val), .byte_done(byte_done),
    .rx_byte(rx_byte), .miso(miso_o)
  );

  logic want_low;
  assign want_low = (st_q == S_IDLE && rsp_pending_i) ||
                    (st_q == S_RECV && rsp_ready_i);

  spi_link_hint #(.MIN_HIGH_CYC(MIN_HIGH_CYC)) u_hint (
    .clk(clk), .rst(rst), .want_low(want_low), .release_i(byte_done),
    .hint_n(hint_n_o)
  );

  // checker: response length bookkeeping
  logic [LW-1:0] take_cnt;
  always_ff @(posedge clk) begin
    if (rst) take_cnt <= '0;
    else if (take) take_cnt <= (st_q == S_RECV) ? LW'(1) : take_cnt + 1'b1;
  end

  a_r1_fill_in_recv: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_RECV && $past(st_q == S_RECV) && $past(st_q == S_RECV, 2)) |-> miso_o);

  a_r3_first_not_fill: assert property (@(posedge clk) disable iff (rst)
    (take && st_q == S_RECV) |-> (rsp_data_i != FILL));

  a_r3_length: assert property (@(posedge clk) disable iff (rst)
    (take && rsp_last_i) |->
      (((st_q == S_RECV) ? LW'(1) : take_cnt + 1'b1) >= LW'(RSP_MIN_LEN)) &&
      (((st_q == S_RECV) ? LW'(1) : take_cnt + 1'b1) <= LW'(RSP_MAX_LEN)));

  a_r7_resync: assert property (@(posedge clk) disable iff (rst)
    cs_s |=> (st_q == S_IDLE));

  a_r8_guard: assert property (@(posedge clk) disable iff (rst)
    (st_q == S_GUARD && !cs_s) |=> (st_q == S_GUARD && !rx_valid_o));

  a_r9_no_pending_in_frame: assert property (@(posedge clk) disable iff (rst)
    (!cs_s && $past(!cs_s) && st_q == S_DONE && hint_n_o) |=> hint_n_o);
endmodule

// File: tb/sim_spi_link_engine.sv
module sim_spi_link_engine;
  localparam int HALF = 8;
  localparam int MINH = 1250;

  logic clk = 0;
  always #10 clk = ~clk;

  logic       rst = 1, sck = 0, cs_n = 1, mosi = 0;
  logic       miso, hint_n, rx_valid, rsp_take, rsp_last;
  logic [7:0] rx_byte, rsp_data;
  logic       rsp_req = 0, rsp_pending = 0, rsp_ready;
  logic [7:0] rsp_arr [4];
  int         rsp_len = 0;
  int         idx = 0;

  assign rsp_ready = rsp_req && (idx < rsp_len);
  assign rsp_data  = rsp_arr[idx[1:0]];
  assign rsp_last  = (idx == rsp_len - 1);

  always @(posedge clk) begin
    if (!rsp_req) idx <= 0;
    else if (rsp_take) idx <= idx + 1;
  end

  spi_link_engine u0 (
    .clk(clk), .rst(rst), .sck_i(sck), .cs_n_i(cs_n), .mosi_i(mosi),
    .miso_o(miso), .hint_n_o(hint_n), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid),
    .rsp_ready_i(rsp_ready), .rsp_pending_i(rsp_pending), .rsp_data_i(rsp_data),
    .rsp_last_i(rsp_last), .rsp_take_o(rsp_take)
  );

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // scoreboard for received command bytes (R10)
  logic [7:0] exp_rx [$];
  always @(negedge clk) begin
    if (!rst && rx_valid) begin
      if (exp_rx.size() == 0) check(0, "R10/R8 unexpected rx byte", rx_byte, 0);
      else begin
        logic [7:0] e;
        e = exp_rx.pop_front();
        check(rx_byte == e, "R10 rx byte", rx_byte, e);
      end
    end
  end

  int hi_run = 0, last_hi = 0;
  always @(negedge clk) begin
    if (hint_n) hi_run++;
    else begin
      if (hi_run != 0) last_hi = hi_run;
      hi_run = 0;
    end
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [7:0] tx, input int n, output logic [7:0] rx);
    rx = '0;
    for (int i = 7; i > 7 - n; i--) begin
      mosi = tx[i];
      wait_clk(HALF);
      rx[i] = miso;
      sck = 1;
      wait_clk(HALF);
      sck = 0;
    end
    wait_clk(HALF);
  endtask

  task automatic xfer(input logic [7:0] tx, input bit expect_rx, output logic [7:0] rx);
    if (expect_rx) exp_rx.push_back(tx);
    shift_bits(tx, 8, rx);
  endtask

  task automatic cs_low();
    cs_n = 0;
    wait_clk(2 * HALF);
  endtask

  task automatic cs_high();
    wait_clk(HALF);
    cs_n = 1;
    wait_clk(4 * HALF);
  endtask

  initial begin
    logic [7:0] r;
    rsp_arr[0] = 0; rsp_arr[1] = 0; rsp_arr[2] = 0; rsp_arr[3] = 0;
    wait_clk(6);
    rst = 0;
    wait_clk(4);
    check(miso == 1'b1, "R1 reset miso", miso, 1);
    check(hint_n == 1'b1, "R2 reset hint", hint_n, 1);
    check(rx_valid == 1'b0, "R10 reset rx_valid", rx_valid, 0);

    // command, wait, response
    cs_low();
    xfer(8'h3C, 1, r); check(r == 8'hFF, "R1 cmd byte0 miso", r, 8'hFF);
    xfer(8'h81, 1, r); check(r == 8'hFF, "R1 cmd byte1 miso", r, 8'hFF);
    xfer(8'h00, 1, r); check(r == 8'hFF, "R1 cmd byte2 miso", r, 8'hFF);
    wait_clk(20);
    check(hint_n == 1'b1, "R2 no response yet", hint_n, 1);
    rsp_arr[0] = 8'h04; rsp_arr[1] = 8'hA7; rsp_arr[2] = 8'h5E; rsp_len = 3;
    rsp_req = 1;
    wait_clk(10);
    check(hint_n == 1'b0, "R2 hint low on ready", hint_n, 0);
    xfer(8'hFF, 1, r); check(r == 8'hFF, "R1 poll byte miso", r, 8'hFF);
    check(hint_n == 1'b1, "R4 hint released", hint_n, 1);
    xfer(8'hFF, 0, r); check(r == 8'h04, "R3 rsp byte0", r, 8'h04);
    xfer(8'hFF, 0, r); check(r == 8'hA7, "R3 rsp byte1", r, 8'hA7);
    xfer(8'hFF, 0, r); check(r == 8'h5E, "R3 rsp byte2", r, 8'h5E);
    check(idx == 3, "R3 take count", idx, 3);
    xfer(8'hFF, 0, r); check(r == 8'hFF, "R1 after last rsp", r, 8'hFF);
    rsp_req = 0;
    rsp_pending = 1;
    wait_clk(2000);
    check(hint_n == 1'b1, "R9 pending ignored in frame", hint_n, 1);
    cs_high();
    check(hint_n == 1'b0, "R6 pending with cs idle", hint_n, 0);

    // release inside a frame, then pending hits the hold-off
    cs_low();
    xfer(8'h55, 1, r);
    check(hint_n == 1'b1, "R4 async hint released", hint_n, 1);
    cs_high();
    check(hint_n == 1'b1, "R5 hold-off active", hint_n, 1);
    wait_clk(1400);
    check(hint_n == 1'b0, "R5 falls after hold-off", hint_n, 0);
    check(last_hi >= MINH && last_hi <= MINH + 2, "R5 high duration", last_hi, MINH + 1);
    rsp_pending = 0;
    cs_low();
    xfer(8'hFF, 1, r);
    cs_high();
    check(hint_n == 1'b1, "R4 released again", hint_n, 1);
    wait_clk(1300);

    // partial byte then resync
    cs_low();
    shift_bits(8'hF0, 4, r);
    cs_high();
    cs_low();
    xfer(8'hA5, 1, r); check(r == 8'hFF, "R7 fresh frame miso", r, 8'hFF);
    cs_high();

    // abort in the middle of a response
    cs_low();
    xfer(8'h12, 1, r);
    rsp_arr[0] = 8'h22; rsp_arr[1] = 8'h33; rsp_arr[2] = 8'h44; rsp_len = 3;
    rsp_req = 1;
    wait_clk(10);
    xfer(8'hFF, 1, r);
    xfer(8'hFF, 0, r); check(r == 8'h22, "R3 abort rsp byte0", r, 8'h22);
    cs_high();
    rsp_req = 0;
    cs_low();
    xfer(8'h66, 1, r); check(r == 8'hFF, "R7 after abort miso", r, 8'hFF);
    cs_high();

    // reset ends with chip select low
    cs_n = 0;
    wait_clk(4);
    rst = 1;
    wait_clk(5);
    rst = 0;
    wait_clk(2 * HALF);
    xfer(8'h9C, 0, r); check(r == 8'hFF, "R8 guard miso byte0", r, 8'hFF);
    xfer(8'h3A, 0, r); check(r == 8'hFF, "R8 guard miso byte1", r, 8'hFF);
    cs_high();
    cs_low();
    xfer(8'h47, 1, r); check(r == 8'hFF, "R8 frame after guard", r, 8'hFF);
    cs_high();
    wait_clk(20);
    check(exp_rx.size() == 0, "R10 all rx bytes seen", exp_rx.size(), 0);

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule